// File: doc/BRIEF.md
# Speculative Load Verification Table

This block lets a compiler-scheduled load be moved above stores that precede it in program order and confirmed later. When a speculative load issues, it files its word address in a small table slot chosen by a tag carried in the instruction. Every store that follows compares its word address against all live slots in parallel and marks any slot holding the same address as disturbed. A later verify operation names the same tag. The table then reports either that the early load value is safe to use, or that it is stale.

A stale result is reported in one of two ways, picked per verify operation. The first is a request to reissue the load. The second is a redirect pulse carrying a fix-up code address that came in with the verify operation. Every verify frees the slot it names. A speculative load that lands on a slot already in use replaces its contents. Addresses are compared at whole-word granularity. The data memory and the reissue itself sit outside the block.

Top module: `spec_ld_guard`

## Requirements
- R1: After reset every slot is empty and all result outputs are low. A verify of any tag issued before any load reports a failure.
- R2: A speculative load with tag T fills slot T with its address. A verify of T with no matching store in between reports pass (vf_done=1, vf_pass=1).
- R3: A store whose word address equals the address in a filled slot marks that slot disturbed. A later verify of that slot fails. A store to any other address leaves the slot undisturbed.
- R4: One store marks every filled slot whose address matches, all in the same cycle. Slots holding other addresses are untouched.
- R5: A store in the same cycle as a speculative load, with the store address equal to the load address, leaves the new slot disturbed.
- R6: A store in the same cycle as a verify, with the store address equal to the verified slot's address, makes that verify fail.
- R7: A verify empties its slot whether it passes or fails. A second verify of the same tag with no new load between fails.
- R8: A speculative load to a filled slot replaces the address and clears the disturbed mark.
- R9: The result of a verify issued in cycle N appears on the outputs in cycle N+1 only. vf_done is 1 exactly one cycle after each verify and 0 otherwise. Outputs of a verify are all 0 when no verify was issued in the previous cycle.
- R10: On failure with vf_fixup_en=1, the block pulses fix_redirect and presents fix_target equal to the vf_fixup_pc given with the verify. With vf_fixup_en=0 it pulses reload_req instead. fix_target is 0 whenever fix_redirect is 0. Exactly one of vf_pass, reload_req and fix_redirect is 1 when vf_done is 1.
- R11: A speculative load and a verify that name the same tag in the same cycle work as follows. The verify is judged on the slot's old contents. The slot then holds the new load, undisturbed unless R5 applies.
- R12: A store before a speculative load never marks that load's slot. Stores to empty slots have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_vld | input | 1 | Speculative load issues this cycle |
| ld_tag | input | TAG_W | Slot chosen by the load |
| ld_addr | input | ADDR_W | Word address of the load |
| st_vld | input | 1 | Store issues this cycle |
| st_addr | input | ADDR_W | Word address of the store |
| vf_vld | input | 1 | Verify issues this cycle |
| vf_tag | input | TAG_W | Slot checked by the verify |
| vf_fixup_en | input | 1 | 1: failure redirects to fix-up code; 0: failure asks for reissue |
| vf_fixup_pc | input | TGT_W | Fix-up code address for this verify |
| vf_done | output | 1 | Verify result valid (one cycle) |
| vf_pass | output | 1 | Early load value is safe |
| reload_req | output | 1 | Failure: reissue the load |
| fix_redirect | output | 1 | Failure: jump to fix-up code |
| fix_target | output | TGT_W | Fix-up address during fix_redirect, else 0 |

## Verification
The bench sweeps every tag through the same-cycle collisions. These are a store alongside the filling load, a store alongside the verify, and a reload alongside the verify. A design that gave the wrong side priority would pass loads it should reject, or keep stale slots. It also checks that a verify frees its slot and that an overwriting load clears the old disturbed mark. A table that forgot either would report spurious failures or repeated passes. Broadcast stores over slots sharing one address catch a match that reaches only one slot. Idle cycles after each verify catch result pulses that stretch or fire without a verify.

// File: rtl/sldg_pkg.sv
`timescale 1ns/1ps
package sldg_pkg;

  typedef enum logic [1:0] {
    VR_NONE     = 2'd0,
    VR_PASS     = 2'd1,
    VR_RELOAD   = 2'd2,
    VR_REDIRECT = 2'd3
  } vres_e;

  // Outcome of a verify given the selected slot state.
  function automatic vres_e judge(input logic filled, input logic disturbed,
                                  input logic fix_en);
    if (filled && !disturbed) return VR_PASS;
    else if (fix_en)          return VR_REDIRECT;
    else                      return VR_RELOAD;
  endfunction

endpackage

// File: rtl/sldg_entry.sv
`timescale 1ns/1ps
module sldg_entry #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              clr_en,
  output logic              filled_o,
  output logic              disturbed_o,
  output logic              st_hit_o
);

  function automatic logic same_word(input logic [ADDR_W-1:0] x,
                                     input logic [ADDR_W-1:0] y);
    return x == y;
  endfunction

  logic              filled_q;
  logic              dist_q;
  logic [ADDR_W-1:0] addr_q;
  logic              born_disturbed;

  // store hitting this slot right now (slot must hold a live load)
  assign st_hit_o       = filled_q && st_en && same_word(addr_q, st_addr);
  // store racing the load that fills the slot
  assign born_disturbed = st_en && same_word(wr_addr, st_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filled_q <= 1'b0;
      dist_q   <= 1'b0;
      addr_q   <= '0;
    end else if (wr_en) begin
      filled_q <= 1'b1;
      addr_q   <= wr_addr;
      dist_q   <= born_disturbed;
    end else if (clr_en) begin
      filled_q <= 1'b0;
      dist_q   <= 1'b0;
    end else if (st_hit_o) begin
      dist_q   <= 1'b1;
    end
  end

  assign filled_o    = filled_q;
  assign disturbed_o = dist_q;

  AST_FILL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> filled_q && addr_q == $past(wr_addr)); // R2
  AST_STORE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    st_hit_o && !wr_en && !clr_en |=> dist_q); // R3
  AST_MARK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dist_q && !wr_en && !clr_en |=> dist_q); // R3
  AST_RACE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && st_en && wr_addr == st_addr |=> dist_q); // R5
  AST_VERIFY_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && !wr_en |=> !filled_q); // R7
  AST_OVERWRITE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !st_en |=> !dist_q); // R8
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !filled_q |-> !dist_q); // R12

endmodule

// File: rtl/sldg_verify.sv
`timescale 1ns/1ps
module sldg_verify
  import sldg_pkg::*;
#(
  parameter int TAG_W   = 3,
  parameter int TGT_W   = 32,
  localparam int SLOTS  = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] filled_vec,
  input  logic [SLOTS-1:0] dist_vec,
  input  logic [SLOTS-1:0] hit_vec,
  input  logic             vf_vld,
  input  logic [TAG_W-1:0] vf_tag,
  input  logic             fix_en,
  input  logic [TGT_W-1:0] fix_pc,
  output logic             done_o,
  output logic             pass_o,
  output logic             reload_o,
  output logic             redirect_o,
  output logic [TGT_W-1:0] target_o
);

  logic  sel_filled;
  logic  sel_dist;
  vres_e res_d, res_q;
  logic [TGT_W-1:0] tgt_d, tgt_q;

  // a store in the verify cycle counts as intervening
  assign sel_filled = filled_vec[vf_tag];
  assign sel_dist   = dist_vec[vf_tag] | hit_vec[vf_tag];

  always_comb begin
    res_d = VR_NONE;
    tgt_d = '0;
    if (vf_vld) begin
      res_d = judge(sel_filled, sel_dist, fix_en);
      if (res_d == VR_REDIRECT) tgt_d = fix_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q <= VR_NONE;
      tgt_q <= '0;
    end else begin
      res_q <= res_d;
      tgt_q <= tgt_d;
    end
  end

  assign done_o     = res_q != VR_NONE;
  assign pass_o     = res_q == VR_PASS;
  assign reload_o   = res_q == VR_RELOAD;
  assign redirect_o = res_q == VR_REDIRECT;
  assign target_o   = tgt_q;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $countones({pass_o, reload_o, redirect_o}) == 1); // R10
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> !pass_o && !reload_o && !redirect_o && target_o == '0); // R9
  AST_TARGET_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_o |-> target_o == '0); // R10

endmodule

// File: rtl/spec_ld_guard.sv
`timescale 1ns/1ps
module spec_ld_guard #(
  parameter int TAG_W  = 3,
  parameter int ADDR_W = 32,
  parameter int TGT_W  = 32,
  localparam int SLOTS = 1 << TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_vld,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_vld,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              vf_vld,
  input  logic [TAG_W-1:0]  vf_tag,
  input  logic              vf_fixup_en,
  input  logic [TGT_W-1:0]  vf_fixup_pc,
  output logic              vf_done,
  output logic              vf_pass,
  output logic              reload_req,
  output logic              fix_redirect,
  output logic [TGT_W-1:0]  fix_target
);

  logic [SLOTS-1:0] wr_vec;
  logic [SLOTS-1:0] clr_vec;
  logic [SLOTS-1:0] filled_vec;
  logic [SLOTS-1:0] dist_vec;
  logic [SLOTS-1:0] hit_vec;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign wr_vec[i]  = ld_vld && (ld_tag == TAG_W'(i));
    assign clr_vec[i] = vf_vld && (vf_tag == TAG_W'(i));

    sldg_entry #(.ADDR_W(ADDR_W)) u_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_vec[i]),
      .wr_addr     (ld_addr),
      .st_en       (st_vld),
      .st_addr     (st_addr),
      .clr_en      (clr_vec[i]),
      .filled_o    (filled_vec[i]),
      .disturbed_o (dist_vec[i]),
      .st_hit_o    (hit_vec[i])
    );
  end

  sldg_verify #(.TAG_W(TAG_W), .TGT_W(TGT_W)) u_verify (
    .clk        (clk),
    .rst_n      (rst_n),
    .filled_vec (filled_vec),
    .dist_vec   (dist_vec),
    .hit_vec    (hit_vec),
    .vf_vld     (vf_vld),
    .vf_tag     (vf_tag),
    .fix_en     (vf_fixup_en),
    .fix_pc     (vf_fixup_pc),
    .done_o     (vf_done),
    .pass_o     (vf_pass),
    .reload_o   (reload_req),
    .redirect_o (fix_redirect),
    .target_o   (fix_target)
  );

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    vf_vld |=> vf_done); // R9
  AST_DONE_ONLY_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    !vf_vld |=> !vf_done); // R9
  AST_REDIRECT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    vf_vld && !vf_fixup_en |=> !fix_redirect); // R10
  AST_RELOAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    vf_vld && vf_fixup_en |=> !reload_req); // R10
  AST_STORE_ON_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
    vf_vld && st_vld && hit_vec[vf_tag] |=> !vf_pass); // R6
  AST_EMPTY_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    vf_vld && !filled_vec[vf_tag] |=> !vf_pass); // R1

endmodule

// File: tb/tb_spec_ld_guard.sv
`timescale 1ns/1ps
module tb_spec_ld_guard;

  localparam int TAG_W = 3;
  localparam int AW    = 32;
  localparam int TW    = 32;
  localparam int N     = 1 << TAG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_vld = 0, st_vld = 0, vf_vld = 0, vf_fixup_en = 0;
  logic [TAG_W-1:0] ld_tag = '0, vf_tag = '0;
  logic [AW-1:0] ld_addr = '0, st_addr = '0;
  logic [TW-1:0] vf_fixup_pc = '0;
  logic vf_done, vf_pass, reload_req, fix_redirect;
  logic [TW-1:0] fix_target;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench-side picture of the table, restated from the requirements
  bit          mv [N];
  bit          mc [N];
  logic [AW-1:0] ma [N];

  always #2 clk = ~clk;

  spec_ld_guard #(.TAG_W(TAG_W), .ADDR_W(AW), .TGT_W(TW)) dut (
    .clk(clk), .rst_n(rst_n),
    .ld_vld(ld_vld), .ld_tag(ld_tag), .ld_addr(ld_addr),
    .st_vld(st_vld), .st_addr(st_addr),
    .vf_vld(vf_vld), .vf_tag(vf_tag),
    .vf_fixup_en(vf_fixup_en), .vf_fixup_pc(vf_fixup_pc),
    .vf_done(vf_done), .vf_pass(vf_pass), .reload_req(reload_req),
    .fix_redirect(fix_redirect), .fix_target(fix_target)
  );

  task automatic check(input string rq, input logic [TW+3:0] got,
                       input logic [TW+3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: {done,pass,reload,redir,target} got=%h exp=%h",
               rq, got, exp);
    end
  endtask

  // One cycle of stimulus; outputs checked one edge later (R9 timing).
  task automatic op(input string rq,
                    input bit l, input int lt, input logic [AW-1:0] la,
                    input bit s, input logic [AW-1:0] sa,
                    input bit v, input int vt, input bit fx,
                    input logic [TW-1:0] tg);
    bit ep;
    logic [TW+3:0] exp;
    exp = '0;
    if (v) begin
      ep  = mv[vt] && !mc[vt] && !(s && sa == ma[vt]);
      exp = {1'b1, ep, !ep && !fx, !ep && fx, (!ep && fx) ? tg : {TW{1'b0}}};
    end
    ld_vld = l; ld_tag = TAG_W'(lt); ld_addr = la;
    st_vld = s; st_addr = sa;
    vf_vld = v; vf_tag = TAG_W'(vt); vf_fixup_en = fx; vf_fixup_pc = tg;
    @(posedge clk);
    #1;
    ld_vld = 0; st_vld = 0; vf_vld = 0;
    for (int i = 0; i < N; i++)
      if (mv[i] && s && sa == ma[i]) mc[i] = 1;
    if (v) begin mv[vt] = 0; mc[vt] = 0; end
    if (l) begin mv[lt] = 1; ma[lt] = la; mc[lt] = s && (sa == la); end
    check(rq, {vf_done, vf_pass, reload_req, fix_redirect, fix_target}, exp);
  endtask

  task automatic ld(input string rq, input int t, input logic [AW-1:0] a);
    op(rq, 1, t, a, 0, '0, 0, 0, 0, '0);
  endtask
  task automatic st(input string rq, input logic [AW-1:0] a);
    op(rq, 0, 0, '0, 1, a, 0, 0, 0, '0);
  endtask
  task automatic vf(input string rq, input int t, input bit fx,
                    input logic [TW-1:0] tg);
    op(rq, 0, 0, '0, 0, '0, 1, t, fx, tg);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; mc[i] = 0; ma[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs low under and right after reset
    check("R1", {vf_done, vf_pass, reload_req, fix_redirect, fix_target}, '0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", {vf_done, vf_pass, reload_req, fix_redirect, fix_target}, '0);
    vf("R1", 3, 0, '0);
    vf("R1", 5, 1, 32'h0000_0777);
    op("R9", 0, 0, '0, 0, '0, 0, 0, 0, '0);

    for (int t = 0; t < N; t++) begin
      logic [AW-1:0] a;
      logic [TW-1:0] tg;
      a  = AW'(t * 37 + 9);
      tg = TW'(32'h8000 + t * 16);
      // R2 plain pass; R3 unrelated store; R9 idle after result
      ld("R2", t, a);
      st("R3", a + 1);
      vf("R2", t, 0, tg);
      op("R9", 0, 0, '0, 0, '0, 0, 0, 0, '0);
      // R3 + R10 redirect form
      ld("R3", t, a);
      st("R3", a);
      vf("R10", t, 1, tg);
      // R7 slot freed after verify
      vf("R7", t, 0, tg);
      // R3 + R10 reload form, then R7 again after a failure
      ld("R3", t, a);
      st("R3", a);
      vf("R10", t, 0, tg);
      vf("R7", t, 1, tg + 1);
      // R8 overwrite clears disturbed mark
      ld("R8", t, a);
      st("R8", a);
      ld("R8", t, a + 2);
      vf("R8", t, 0, tg);
      // R5 store racing the load
      op("R5", 1, t, a, 1, a, 0, 0, 0, '0);
      vf("R5", t, 1, tg);
      // R6 store racing the verify
      ld("R6", t, a);
      op("R6", 0, 0, '0, 1, a, 1, t, 1, tg);
      // R6 control: non-matching store with verify
      ld("R6", t, a);
      op("R6", 0, 0, '0, 1, a + 3, 1, t, 1, tg);
      // R11 load and verify same tag same cycle
      ld("R11", t, a);
      st("R11", a);
      op("R11", 1, t, a + 5, 0, '0, 1, t, 0, tg);
      vf("R11", t, 0, tg);
      // R12 older store, and stores to empty slots
      st("R12", a);
      ld("R12", t, a);
      vf("R12", t, 1, tg);
      st("R12", a);
      ld("R12", t, a);
      vf("R12", t, 0, tg);
    end

    // R4 broadcast: all slots share an address
    for (int t = 0; t < N; t++) ld("R4", t, 32'h55);
    st("R4", 32'h55);
    for (int t = 0; t < N; t++) vf("R4", t, t[0], TW'(t + 1));
    // R4 mixed: even slots match, odd do not
    for (int t = 0; t < N; t++) ld("R4", t, t[0] ? 32'h66 : 32'h55);
    st("R4", 32'h55);
    for (int t = 0; t < N; t++) vf("R4", t, 1, TW'(32'h900 + t));
    op("R9", 0, 0, '0, 0, '0, 0, 0, 0, '0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule